// File: doc/BRIEF.md
# PLL lock-status flag register

This block holds the two status bits that software reads from a clock synthesizer. The first is a sticky loss-of-lock flag. It is set when the synchronized lock indication drops, and software clears it by writing 1 to it. While set, it drives an interrupt request. The second is a loss-of-clock bit that follows the clock monitor's verdict cycle by cycle.

The flag ignores lock drops that are expected:
- drops that follow a reset;
- drops that follow a write which changes the synthesizer's divider, multiplier or mode settings;
- drops that occur while the synthesizer runs in bypass.

For a reconfiguration, a single-cycle pulse opens a suppression window. The window stays open until lock is seen to rise again. Reset opens the same window.

The register is one 32-bit word. Bits are numbered from the most significant end, so bit 0 is the MSB. The lock and loss-of-clock inputs pass through a synchronizer before use. Mode, enable and reconfiguration inputs are taken as synchronous to the register clock.

Top module: `pll_stat_reg`

## Requirements
- R1: The loss-of-lock flag reads at MSB-first bit 22, which is `reg_rd_data[9]`. The loss-of-clock bit reads at MSB-first bit 23, which is `reg_rd_data[8]`. Every other bit of the word reads 0.
- R2: A write with `reg_wdata[9]`=1 clears the loss-of-lock flag. A write with `reg_wdata[9]`=0 leaves it unchanged.
- R3: Once set, the loss-of-lock flag stays set after lock returns, until it is cleared by a write or by reset.
- R4: A falling edge of the synchronized lock input sets the flag when no suppression applies. The flag appears `SYNC_STAGES`+1 rising clock edges after `lock_raw` falls. `irq` equals the flag.
- R5: Reset clears both bits. After reset, lock drops are ignored until lock has first been seen high.
- R6: A `cfg_wr_pulse` opens a window in which lock drops are ignored. The window closes on the next rising edge of the synchronized lock.
- R7: A lock drop seen while `bypass`=1 does not set the flag. Entering bypass does not clear a flag that is already set.
- R8: The loss-of-clock bit equals the synchronized `loc_raw` ANDed with `loc_en` and with NOT `bypass`. It clears by itself when the condition ends.
- R9: If a qualifying lock drop and a write-1 clear fall in the same cycle, the flag ends up set.
- R10: Writes to the loss-of-clock bit and to all read-only bits have no effect on the value read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_raw | input | 1 | Unsynchronized lock indication from the lock detector |
| loc_raw | input | 1 | Unsynchronized loss-of-clock indication from the clock monitor |
| loc_en | input | 1 | Enables reporting of loss-of-clock |
| bypass | input | 1 | 1 while the synthesizer runs in bypass mode |
| cfg_wr_pulse | input | 1 | One-cycle pulse for a write that changes divider, multiplier or mode settings |
| reg_wr | input | 1 | Write strobe for this register |
| reg_wdata | input | 32 | Write data |
| reg_rd_data | output | 32 | Register contents |
| irq | output | 1 | Loss-of-lock interrupt request |

## Verification
The bench uses the default parameters: a 32-bit word, flag positions 22 and 23, and a two-stage synchronizer. With two stages, every status change lands exactly three edges after the raw input moves. That fixed latency lets a write-1 clear be placed on the very edge where a lock drop takes effect, which checks the precedence rule. The short, known latency also lets each table vector settle within five cycles, so suppression windows, the bypass transitions and the loss-of-clock masking can each be stepped through in order.

// File: rtl/pll_stat_pkg.sv
package pll_stat_pkg;

    typedef struct packed {
        logic lolf;
        logic loc;
    } stat_flags_t;

    typedef struct packed {
        logic lock_prev;
        logic supp;
    } det_state_t;

endpackage

// File: rtl/pll_stat_sync.sv
module pll_stat_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q_out = stg_q[STAGES-1];
endmodule

// File: rtl/pll_stat_lol_det.sv
module pll_stat_lol_det
    import pll_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_s,
    input  logic cfg_wr_pulse,
    input  logic bypass,
    output logic lol_set
);
    det_state_t st_d, st_q;
    logic rise, fall;

    always_comb begin
        rise = lock_s & ~st_q.lock_prev;
        fall = ~lock_s & st_q.lock_prev;
        st_d = st_q;
        st_d.lock_prev = lock_s;
        if (cfg_wr_pulse)  st_d.supp = 1'b1;
        else if (rise)     st_d.supp = 1'b0;
        lol_set = fall & ~st_q.supp & ~cfg_wr_pulse & ~bypass;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lock_prev <= 1'b0;
            st_q.supp      <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    cfg_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_pulse |=> !lol_set);

    // R4
    set_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lol_set |-> ($past(lock_s) && !lock_s));
endmodule

// File: rtl/pll_stat_reg.sv
module pll_stat_reg
    import pll_stat_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int LOLF_BIT    = 22,
    parameter int LOC_BIT     = 23,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_raw,
    input  logic              loc_raw,
    input  logic              loc_en,
    input  logic              bypass,
    input  logic              cfg_wr_pulse,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rd_data,
    output logic              irq
);
    localparam int LOLF_IDX = DATA_W - 1 - LOLF_BIT;
    localparam int LOC_IDX  = DATA_W - 1 - LOC_BIT;
    localparam logic [DATA_W-1:0] RD_MASK =
        (DATA_W'(1) << LOLF_IDX) | (DATA_W'(1) << LOC_IDX);

    logic lock_s, loc_s, lol_set, wr_clr;
    stat_flags_t flg_d, flg_q;

    pll_stat_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({loc_raw, lock_raw}),
        .q_out ({loc_s, lock_s})
    );

    pll_stat_lol_det u_det (
        .clk          (clk),
        .rst_n        (rst_n),
        .lock_s       (lock_s),
        .cfg_wr_pulse (cfg_wr_pulse),
        .bypass       (bypass),
        .lol_set      (lol_set)
    );

    always_comb begin
        wr_clr     = reg_wr & reg_wdata[LOLF_IDX];
        flg_d.lolf = lol_set | (flg_q.lolf & ~wr_clr);
        flg_d.loc  = loc_s & loc_en & ~bypass;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    always_comb begin
        reg_rd_data           = '0;
        reg_rd_data[LOLF_IDX] = flg_q.lolf;
        reg_rd_data[LOC_IDX]  = flg_q.loc;
    end

    assign irq = flg_q.lolf;

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lol_set |=> irq);

    // R3
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_wr && reg_wdata[LOLF_IDX])) |=> irq);

    // R2
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[LOLF_IDX] && !lol_set) |=> !irq);

    // R7
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && !irq) |=> !irq);

    // R8
    loc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!loc_en || bypass) |=> !reg_rd_data[LOC_IDX]);

    // R1
    ro_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data & ~RD_MASK) == '0);

    // R10
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (|(reg_wdata & ~RD_MASK))) |=> ((reg_rd_data & ~RD_MASK) == '0));
endmodule

// File: tb/tb_pll_stat_reg.sv
module tb_pll_stat_reg;
    localparam logic [31:0] CLR  = 32'h0000_0200;
    localparam logic [31:0] NCLR = ~CLR;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    typedef struct packed {
        logic        lock, loc, en, byp, cfg, wr;
        logic [31:0] wd;
        logic        el, ec;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,1'b0,1'b0}, // R5 first lock
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,1'b1,1'b0}, // R4 drop sets
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,1'b1,1'b0}, // R3 sticky
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,CLR  ,1'b0,1'b0}, // R2 clear
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,1'b1,1'b0}, // R4
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,NCLR ,1'b1,1'b0}, // R2 write 0, R10
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,CLR  ,1'b0,1'b0}, // R2
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,32'h0,1'b0,1'b0}, // R6 open window
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,1'b0,1'b0}, // R6 drop ignored
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,1'b0,1'b0}, // R6 relock closes
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,1'b1,1'b0}, // R6 window closed
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,CLR  ,1'b0,1'b0}, // R2
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,1'b0,1'b0}, // R7 bypass drop
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,1'b0,1'b0}, // R7
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,1'b1,1'b0}, // R4
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,1'b1,1'b0}, // R7 no clear
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,CLR  ,1'b0,1'b0}, // R2
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0,1'b0,1'b0}, // R8 disabled
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,32'h0,1'b0,1'b1}, // R8 live
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,32'h0,1'b0,1'b0}, // R8 bypass mask
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,32'h0,1'b0,1'b1}, // R8
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,ONES ,1'b0,1'b1}, // R10 write all
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,32'h0,1'b0,1'b0}  // R8 self clear
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_raw = 1'b0, loc_raw = 1'b0, loc_en = 1'b0, bypass = 1'b0;
    logic        cfg_wr_pulse = 1'b0, reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rd_data;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int cyc = 0;

    always #4 clk = ~clk;

    pll_stat_reg dut (
        .clk(clk), .rst_n(rst_n), .lock_raw(lock_raw), .loc_raw(loc_raw),
        .loc_en(loc_en), .bypass(bypass), .cfg_wr_pulse(cfg_wr_pulse),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd_data(reg_rd_data),
        .irq(irq)
    );

    function automatic logic [31:0] word(input logic lolf, input logic loc);
        return (32'(lolf) << 9) | (32'(loc) << 8);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 5000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R5 reset word", reg_rd_data, 32'h0);
        chk("R5 reset irq", 32'(irq), 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            lock_raw = VEC[v].lock; loc_raw = VEC[v].loc;
            loc_en = VEC[v].en; bypass = VEC[v].byp;
            cfg_wr_pulse = VEC[v].cfg; reg_wr = VEC[v].wr; reg_wdata = VEC[v].wd;
            @(negedge clk);
            cfg_wr_pulse = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
            repeat (4) @(negedge clk);
            chk($sformatf("R1 vector %0d word", v), reg_rd_data, word(VEC[v].el, VEC[v].ec));
            chk($sformatf("R4 vector %0d irq", v), 32'(irq), 32'(VEC[v].el));
        end

        // R4 latency and R9 same-cycle set/clear; lock is high, flag clear
        loc_raw = 1'b0; loc_en = 1'b0;
        lock_raw = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk("R4 not yet after two edges", 32'(irq), 32'h0);
        reg_wr = 1'b1; reg_wdata = CLR;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_wdata = '0;
        chk("R9 set wins over clear", reg_rd_data, word(1'b1, 1'b0));
        @(negedge clk);

        // R5 reset clears a set flag; drop held through reset stays ignored
        rst_n = 1'b0;
        @(negedge clk);
        chk("R5 reset clears flag", reg_rd_data, 32'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R5 no flag after reset", reg_rd_data, 32'h0);

        // R5 lock seen high then dropped after reset does set the flag
        lock_raw = 1'b1;
        repeat (5) @(negedge clk);
        lock_raw = 1'b0;
        repeat (5) @(negedge clk);
        chk("R5 armed after first lock", reg_rd_data, word(1'b1, 1'b0));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule